// File: doc/BRIEF.md
# PLL Clock Switchover Sequencer

This block moves a chip's system clock from a crystal source, divided by nine, to a PLL output clock. It also enforces the conditions under which the move is safe. A host programs the PLL through a register-write port, which carries an address and a strobe. The block watches those writes. It starts a settle window when the last configuration register is written. It counts frame-sync edges in that window. The request to change clocks is honoured only when both of these hold: the host has asked for the change, and the settle window has covered two frame-sync edges.

The clock change itself goes through a glitch-free multiplexer. The multiplexer synchronizes the select into each clock domain with two flops. It turns the outgoing clock off on that clock's falling edge. Only after that does it turn the incoming clock on, on the incoming clock's falling edge. A status output reports when the PLL clock has taken over.

Alongside the switchover, the block drives a boost enable for the PLL charge pump. The boost is held high until the PLL reports lock or the host sets a force bit, whichever comes first. It is raised again whenever the PLL is reprogrammed.

Top module: `clksw_top`

## Requirements
- R1: After reset, `clk_sel` is 0, `pll_active` is 0 and `cp_boost` is 1.
- R2: While the crystal side is selected, `sys_clk` runs at the crystal rate divided by DIV (9 by default).
- R3: Without a write to address 0x0E, the system clock never leaves the crystal side, whatever configuration writes and frame-sync edges occur. Once `clk_sel` is 1 it stays 1 until reset.
- R4: `clk_sel` rises only after both of these: two synchronized frame-sync rising edges seen since the last write to 0x0D, and a write to 0x0E. A 0x0E write that comes early is held. The switch then follows the second edge within two `clk_xtal` cycles.
- R5: Any write to an address from 0x08 to 0x0D restarts the frame-sync count. A write from 0x08 to 0x0C also cancels the armed state, so 0x0D must be written again before edges count.
- R6: A write to an address outside 0x08 to 0x0E changes nothing: neither the frame-sync count nor the boost.
- R7: The clock handover creates no high or low phase on `sys_clk` shorter than the shorter half-period of the two source clocks.
- R8: `pll_active` becomes 1 only after `clk_sel` is 1. From then on, `sys_clk` runs at the PLL rate.
- R9: `cp_boost` falls one cycle after synchronized `lock_det` or `force_vco` is seen high, whichever comes first. It stays low after `lock_det` drops.
- R10: A write to any address from 0x08 to 0x0D sets `cp_boost` to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock; clocks the sequencer |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register-write strobe, one `clk_xtal` cycle |
| wr_addr | input | ADDR_W | Host register-write address |
| fsync | input | 1 | Frame-sync, asynchronous |
| lock_det | input | 1 | PLL lock indication, asynchronous |
| force_vco | input | 1 | Host bit that forces the boost off, synchronous to `clk_xtal` |
| sys_clk | output | 1 | Muxed system clock |
| clk_sel | output | 1 | Select sent to the mux; 1 asks for the PLL clock |
| pll_active | output | 1 | PLL clock has taken over |
| cp_boost | output | 1 | Charge-pump high-current enable |

## Verification
`cp_boost` answers a configuration write on the next `clk_xtal` edge. It answers `lock_det` three edges after the input changes: two synchronizer edges and one register edge. `clk_sel` rises at most about four edges after the second frame-sync rise, because two synchronizer flops, the edge detector and the phase register lie in the path. The bench therefore samples at a falling edge at least eight cycles after each stimulus. For the "must not switch" checks it uses the same distance, or more. `pll_active` passes through synchronizers in three clock domains, so it is checked forty cycles after the select. The clock rate is judged by counting `sys_clk` rising edges over a fixed window and allowing one edge of slack. Phase widths are measured on every `sys_clk` toggle across the handover.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  // Progress of the sequencer towards the PLL clock.
  typedef enum logic [1:0] {
    PH_UNCFG  = 2'd0,  // configuration not finished
    PH_SETTLE = 2'd1,  // last config register written, counting frame edges
    PH_READY  = 2'd2,  // settle window satisfied, waiting for host request
    PH_PLL    = 2'd3   // PLL clock selected (sticky until reset)
  } clksw_phase_e;

endpackage

// File: rtl/clksw_rst_sync.sv
module clksw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_prescale.sv
module clksw_prescale #(
  parameter int unsigned DIV = 9
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_div
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HIGH = CW'(DIV / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          div_q, div_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    div_d = (cnt_d < HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign clk_div = div_q;

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CFG_FIRST = 8'h08,
  parameter int unsigned CFG_LAST  = 8'h0D,
  parameter int unsigned REQ_ADDR  = 8'h0E,
  parameter int unsigned FS_WAIT   = 2,
  parameter int unsigned SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              fsync_a,
  input  logic              lock_a,
  input  logic              force_vco,
  output logic              clk_sel,
  output logic              cp_boost
);

  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_FIRST);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_LAST);
  localparam logic [ADDR_W-1:0] REQ_A  = ADDR_W'(REQ_ADDR);
  localparam int unsigned       FCW    = $clog2(FS_WAIT + 1);
  localparam logic [FCW-1:0]    WAIT_M1 = FCW'(FS_WAIT - 1);

  logic fs_s, lock_s, fs_prev_q, fs_rise;
  logic cfg_wr, cfg_last, req_wr;

  clksw_phase_e   phase_q, phase_d;
  logic [FCW-1:0] cnt_q, cnt_d;
  logic           req_q, req_d;
  logic           boost_q, boost_d;

  clksw_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .d(fsync_a), .q(fs_s)
  );

  clksw_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .rst_n(rst_n), .d(lock_a), .q(lock_s)
  );

  assign fs_rise  = fs_s & ~fs_prev_q;
  assign cfg_wr   = wr_en && (wr_addr >= CFG_LO) && (wr_addr <= CFG_HI);
  assign cfg_last = cfg_wr && (wr_addr == CFG_HI);
  assign req_wr   = wr_en && (wr_addr == REQ_A);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    req_d   = req_q | req_wr;
    boost_d = boost_q;

    if (cfg_wr) begin
      boost_d = 1'b1;
    end else if (lock_s || force_vco) begin
      boost_d = 1'b0;
    end

    if (phase_q != PH_PLL) begin
      if (cfg_wr) begin
        cnt_d   = '0;
        phase_d = cfg_last ? PH_SETTLE : PH_UNCFG;
      end else begin
        unique case (phase_q)
          PH_SETTLE: begin
            if (fs_rise) begin
              cnt_d = cnt_q + 1'b1;
              if (cnt_q == WAIT_M1) begin
                phase_d = PH_READY;
              end
            end
          end
          PH_READY: begin
            if (req_q) begin
              phase_d = PH_PLL;
            end
          end
          default: begin
            phase_d = phase_q;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_UNCFG;
      cnt_q     <= '0;
      req_q     <= 1'b0;
      boost_q   <= 1'b1;
      fs_prev_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      req_q     <= req_d;
      boost_q   <= boost_d;
      fs_prev_q <= fs_s;
    end
  end

  assign clk_sel  = (phase_q == PH_PLL);
  assign cp_boost = boost_q;

endmodule

// File: rtl/clksw_gate_side.sv
module clksw_gate_side #(
  parameter int unsigned SYNC    = 2,
  parameter bit          EN_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic en
);

  logic want_s;
  logic en_q;

  clksw_sync #(.STAGES(SYNC), .RST_VAL(EN_INIT)) u_want_sync (
    .clk(clk), .rst_n(rst_n), .d(want), .q(want_s)
  );

  // Enable changes while this clock is low, so its gated copy never chops.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_INIT;
    end else begin
      en_q <= want_s;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/clksw_gfmux.sv
module clksw_gfmux #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_a,
  input  logic rst_a_n,
  input  logic clk_b,
  input  logic rst_b_n,
  input  logic sel_b,
  output logic en_a,
  output logic en_b,
  output logic clk_o
);

  logic want_a, want_b;

  // Each side may only turn on once the other side is confirmed off.
  assign want_a = ~sel_b & ~en_b;
  assign want_b =  sel_b & ~en_a;

  clksw_gate_side #(.SYNC(SYNC), .EN_INIT(1'b1)) u_side_a (
    .clk(clk_a), .rst_n(rst_a_n), .want(want_a), .en(en_a)
  );

  clksw_gate_side #(.SYNC(SYNC), .EN_INIT(1'b0)) u_side_b (
    .clk(clk_b), .rst_n(rst_b_n), .want(want_b), .en(en_b)
  );

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);

endmodule

// File: rtl/clksw_top.sv
module clksw_top #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIV       = 9,
  parameter int unsigned CFG_FIRST = 8'h08,
  parameter int unsigned CFG_LAST  = 8'h0D,
  parameter int unsigned REQ_ADDR  = 8'h0E,
  parameter int unsigned FS_WAIT   = 2,
  parameter int unsigned SYNC      = 2
) (
  input  logic              clk_xtal,
  input  logic              clk_pll,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              fsync,
  input  logic              lock_det,
  input  logic              force_vco,
  output logic              sys_clk,
  output logic              clk_sel,
  output logic              pll_active,
  output logic              cp_boost
);

  logic rst_x_n, rst_d_n, rst_p_n;
  logic clk_div;
  logic en_div, en_pll;

  clksw_rst_sync #(.STAGES(SYNC)) u_rst_x (
    .clk(clk_xtal), .arst_n(rst_n), .rst_n_o(rst_x_n)
  );

  clksw_prescale #(.DIV(DIV)) u_prescale (
    .clk(clk_xtal), .rst_n(rst_x_n), .clk_div(clk_div)
  );

  clksw_rst_sync #(.STAGES(SYNC)) u_rst_d (
    .clk(clk_div), .arst_n(rst_x_n), .rst_n_o(rst_d_n)
  );

  clksw_rst_sync #(.STAGES(SYNC)) u_rst_p (
    .clk(clk_pll), .arst_n(rst_n), .rst_n_o(rst_p_n)
  );

  clksw_seq #(
    .ADDR_W(ADDR_W), .CFG_FIRST(CFG_FIRST), .CFG_LAST(CFG_LAST),
    .REQ_ADDR(REQ_ADDR), .FS_WAIT(FS_WAIT), .SYNC(SYNC)
  ) u_seq (
    .clk(clk_xtal), .rst_n(rst_x_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .fsync_a(fsync), .lock_a(lock_det), .force_vco(force_vco),
    .clk_sel(clk_sel), .cp_boost(cp_boost)
  );

  clksw_gfmux #(.SYNC(SYNC)) u_mux (
    .clk_a(clk_div), .rst_a_n(rst_d_n), .clk_b(clk_pll), .rst_b_n(rst_p_n),
    .sel_b(clk_sel), .en_a(en_div), .en_b(en_pll), .clk_o(sys_clk)
  );

  clksw_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_status_sync (
    .clk(clk_xtal), .rst_n(rst_x_n), .d(en_pll), .q(pll_active)
  );

endmodule

// File: rtl/clksw_top_chk.sv
module clksw_top_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CFG_FIRST = 8'h08,
  parameter int unsigned CFG_LAST  = 8'h0D,
  parameter int unsigned REQ_ADDR  = 8'h0E,
  parameter int unsigned FS_WAIT   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              fs_rise,
  input logic              lock_s,
  input logic              force_vco,
  input logic              clk_sel,
  input logic              cp_boost,
  input logic              pll_active
);

  localparam logic [ADDR_W-1:0] LO  = ADDR_W'(CFG_FIRST);
  localparam logic [ADDR_W-1:0] HI  = ADDR_W'(CFG_LAST);
  localparam logic [ADDR_W-1:0] REQ = ADDR_W'(REQ_ADDR);

  logic        cfg_wr;
  int unsigned seen_q;
  logic        armed_q, asked_q;

  assign cfg_wr = wr_en && (wr_addr >= LO) && (wr_addr <= HI);

  // Independent count of settle-window edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 0;
      armed_q <= 1'b0;
      asked_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == REQ) asked_q <= 1'b1;
      if (cfg_wr) begin
        seen_q  <= 0;
        armed_q <= (wr_addr == HI);
      end else if (fs_rise && seen_q < FS_WAIT) begin
        seen_q <= seen_q + 1;
      end
    end
  end

  a_r4_sel_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> (armed_q && asked_q && seen_q >= FS_WAIT));

  a_r3_sel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |=> clk_sel);

  a_r9_boost_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && (lock_s || force_vco)) |=> !cp_boost);

  a_r9_boost_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_boost && !cfg_wr) |=> !cp_boost);

  a_r10_boost_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cp_boost);

  a_r8_active_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    pll_active |-> clk_sel);

endmodule

bind clksw_top clksw_top_chk #(
  .ADDR_W(ADDR_W), .CFG_FIRST(CFG_FIRST), .CFG_LAST(CFG_LAST),
  .REQ_ADDR(REQ_ADDR), .FS_WAIT(FS_WAIT)
) u_chk (
  .clk(clk_xtal), .rst_n(rst_x_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .fs_rise(u_seq.fs_rise), .lock_s(u_seq.lock_s), .force_vco(force_vco),
  .clk_sel(clk_sel), .cp_boost(cp_boost), .pll_active(pll_active)
);

// File: tb/clksw_top_bench.sv
`timescale 1ns/1ps
module clksw_top_bench;

  logic       clk_xtal = 1'b0;
  logic       clk_pll  = 1'b0;
  logic       rst_n, wr_en, fsync, lock_det, force_vco;
  logic [7:0] wr_addr;
  logic       sys_clk, clk_sel, pll_active, cp_boost;

  int  checks = 0;
  int  errors = 0;
  int  edge_cnt = 0;
  bit  meas = 1'b0;
  realtime last_t = 0.0;
  realtime min_w  = 1.0e9;

  always #4 clk_xtal = ~clk_xtal;
  always #3 clk_pll  = ~clk_pll;

  clksw_top u_clksw_top (
    .clk_xtal(clk_xtal), .clk_pll(clk_pll), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .fsync(fsync),
    .lock_det(lock_det), .force_vco(force_vco),
    .sys_clk(sys_clk), .clk_sel(clk_sel),
    .pll_active(pll_active), .cp_boost(cp_boost)
  );

  always @(posedge sys_clk) edge_cnt++;

  always @(sys_clk) begin
    if (meas && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act,
                         input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_xtal);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 8'h00;
    fsync = 1'b0; lock_det = 1'b0; force_vco = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(12);
  endtask

  task automatic wr(input logic [7:0] a);
    wr_en = 1'b1; wr_addr = a;
    cyc(1);
    wr_en = 1'b0;
    cyc(1);
  endtask

  task automatic cfg_all();
    for (int a = 8; a <= 13; a++) wr(8'(a));
  endtask

  task automatic fs_pulse();
    fsync = 1'b1; cyc(3);
    fsync = 1'b0; cyc(5);
  endtask

  task automatic sys_edges(input int n, output int c);
    int s;
    s = edge_cnt;
    cyc(n);
    c = edge_cnt - s;
  endtask

  // R1, R2: reset state and divided crystal rate
  task automatic t_reset();
    int c;
    do_reset();
    chk("R1", "clk_sel", clk_sel, 0);
    chk("R1", "pll_active", pll_active, 0);
    chk("R1", "cp_boost", cp_boost, 1);
    sys_edges(90, c);
    chk_rng("R2", "sys_clk edges in 90 xtal cycles", c, 9, 11);
  endtask

  // R3: no switch without the 0x0E request
  task automatic t_no_request();
    int c;
    do_reset();
    cfg_all();
    fs_pulse(); fs_pulse(); fs_pulse();
    cyc(20);
    chk("R3", "clk_sel without request", clk_sel, 0);
    chk("R3", "pll_active without request", pll_active, 0);
    sys_edges(90, c);
    chk_rng("R3", "sys_clk still divided", c, 9, 11);
  endtask

  // R4, R7, R8: early request latched, switch after the second edge
  task automatic t_early_request();
    int c;
    do_reset();
    cfg_all();
    wr(8'h0E);
    meas = 1'b1; min_w = 1.0e9;
    cyc(10);
    chk("R4", "clk_sel before any frame edge", clk_sel, 0);
    fs_pulse();
    cyc(20);
    chk("R4", "clk_sel after one frame edge", clk_sel, 0);
    fs_pulse();
    chk("R4", "clk_sel after second frame edge", clk_sel, 1);
    cyc(40);
    chk("R8", "pll_active after handover", pll_active, 1);
    sys_edges(60, c);
    chk_rng("R8", "sys_clk edges in 60 xtal cycles", c, 79, 81);
    meas = 1'b0;
    chk("R7", "shortest sys_clk phase >= 2.9 ns", (min_w >= 2.9) ? 1 : 0, 1);
  endtask

  // R5: configuration writes restart the window; 0x0D must come last
  task automatic t_restart();
    do_reset();
    wr(8'h0D);
    wr(8'h0E);
    fs_pulse();
    wr(8'h0A);
    fs_pulse(); fs_pulse();
    cyc(10);
    chk("R5", "clk_sel after 0x0A without 0x0D", clk_sel, 0);
    wr(8'h0D);
    fs_pulse();
    cyc(10);
    chk("R5", "clk_sel one edge after fresh 0x0D", clk_sel, 0);
    fs_pulse();
    chk("R5", "clk_sel two edges after fresh 0x0D", clk_sel, 1);
  endtask

  // R6: writes outside the decoded range have no effect
  task automatic t_ignored();
    do_reset();
    wr(8'h0D);
    wr(8'h0E);
    fs_pulse();
    lock_det = 1'b1; cyc(6);
    lock_det = 1'b0; cyc(2);
    chk("R6", "cp_boost after lock", cp_boost, 0);
    wr(8'h07); wr(8'h0F); wr(8'h20);
    cyc(4);
    chk("R6", "cp_boost after out-of-range writes", cp_boost, 0);
    chk("R6", "clk_sel after one edge", clk_sel, 0);
    fs_pulse();
    chk("R6", "clk_sel: count kept across ignored writes", clk_sel, 1);
  endtask

  // R9, R10: boost release on lock or force, re-arm on config write
  task automatic t_boost();
    do_reset();
    cyc(10);
    chk("R9", "cp_boost held with no lock", cp_boost, 1);
    lock_det = 1'b1; cyc(5);
    chk("R9", "cp_boost after lock", cp_boost, 0);
    lock_det = 1'b0; cyc(5);
    chk("R9", "cp_boost stays low after lock drops", cp_boost, 0);
    wr(8'h09);
    chk("R10", "cp_boost re-armed by 0x09", cp_boost, 1);
    force_vco = 1'b1; cyc(2);
    chk("R9", "cp_boost after force", cp_boost, 0);
    force_vco = 1'b0;
    wr(8'h0D);
    chk("R10", "cp_boost re-armed by 0x0D", cp_boost, 1);
    lock_det = 1'b1; cyc(5);
    chk("R9", "cp_boost after second lock", cp_boost, 0);
    lock_det = 1'b0;
  endtask

  initial begin
    t_reset();
    t_no_request();
    t_early_request();
    t_restart();
    t_ignored();
    t_boost();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule